// File: doc/BRIEF.md
# Periodic Rate and Square-Wave Generator

This block turns a reference-clock enable into the timing strobes of a real-time clock. A prescaler brings the reference down to a common base rate of 32768 events per second. A 15-bit chain counter then divides that base rate to produce a once-per-second tick for the timekeeping logic. It also gives a set of binary taps, and a 4-bit rate code picks one of them. The chosen tap drives a periodic event pulse and, when enabled, a square-wave pin.

A 3-bit divider code tells the prescaler which reference frequency is fitted. The same code can also stop the chain, or hold it cleared. The block runs in the system clock domain. `ref_en` is high for one system cycle per reference period. All pulses are registered, so each appears in the cycle after the clock edge that caused it.

Top module: `rate_divider`

## Requirements
- R1: While `rst_n` is low, `tick_1hz`, `per_pulse` and `sqw_out` are all low.
- R2: Divider code 3'b000 gives one base event per 128 `ref_en` cycles, 3'b001 one per 32, and 3'b010 one per `ref_en` cycle.
- R3: Divider codes 3'b110 and 3'b111 clear the prescaler and the chain and keep them cleared. While either code is applied, `tick_1hz` and `per_pulse` stay low and `sqw_out` is low.
- R4: Divider codes 3'b011, 3'b100 and 3'b101 freeze the chain without clearing it. No pulse occurs, and `sqw_out` keeps its level.
- R5: Rate code 0 gives no `per_pulse`, and `sqw_out` stays low.
- R6: For rate code r from 2 to 15, `per_pulse` is a one-cycle pulse every 2^(r-1) base events. For code 1 it pulses on every base event.
- R7: For rate codes 2 to 15, `sqw_out` is a 50% duty wave with a period of 2^(r-1) base events. For code 1 it is high for one cycle on each base event.
- R8: With `sqw_en` low, `sqw_out` is low.
- R9: `tick_1hz` is a one-cycle pulse every 32768 base events. After a clear code is released, the first tick follows exactly 32768 base events later.
- R10: A cycle with `ref_en` low advances nothing. The following cycle has no `tick_1hz` and no `per_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle strobe per reference clock period |
| div_sel | input | 3 | Reference/divider control code |
| rate_sel | input | 4 | Periodic rate code |
| sqw_en | input | 1 | Square-wave output enable |
| tick_1hz | output | 1 | Once-per-second pulse |
| per_pulse | output | 1 | Periodic event pulse |
| sqw_out | output | 1 | Square-wave output |

## Verification
The assertions assume that the control inputs change only between clock edges. They also assume that the clear codes act at the edge where they are sampled, so a clear code seen at one edge leaves no pulse in the next cycle. The bench drives every input on the falling edge and samples on the falling edge as well. Rates are measured by counting cycles between pulses rather than by timing edges against the clock. Each rate is measured only after one full settling period following a code change, so intervals that straddle a change are never checked.

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int BASE_W  = 15,
  parameter int PRE_HI  = 7,
  parameter int PRE_MID = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic [2:0] div_sel,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  output logic       tick_1hz,
  output logic       per_pulse,
  output logic       sqw_out
);
  localparam logic [PRE_HI-1:0] MASK_HI  = '1;
  localparam logic [PRE_HI-1:0] MASK_MID = PRE_HI'((1 << PRE_MID) - 1);

  logic [PRE_HI-1:0] pre, pre_mask;
  logic [BASE_W-1:0] cnt, low_mask;
  logic [3:0]        tap;
  logic              base_q, tick_q, per_q;

  wire hold = div_sel[2] & div_sel[1];
  wire run  = ~div_sel[2] & ~(div_sel[1] & div_sel[0]);

  always_comb begin
    case (div_sel)
      3'b000:  pre_mask = MASK_HI;
      3'b001:  pre_mask = MASK_MID;
      default: pre_mask = '0;
    endcase
  end

  wire base_ev = ref_en & run & ((pre & pre_mask) == pre_mask);

  assign tap      = (rate_sel >= 4'd2) ? rate_sel - 4'd2 : 4'd0;
  assign low_mask = (BASE_W'(1) << tap) - BASE_W'(1);

  wire rise    = ~cnt[tap] & ((cnt & low_mask) == low_mask);
  wire per_hit = (rate_sel == 4'd1) | ((rate_sel != 4'd0) & rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre    <= '0;
      cnt    <= '0;
      base_q <= 1'b0;
      tick_q <= 1'b0;
      per_q  <= 1'b0;
    end else if (hold) begin
      pre    <= '0;
      cnt    <= '0;
      base_q <= 1'b0;
      tick_q <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      if (ref_en & run) pre <= pre + 1'b1;
      if (base_ev)      cnt <= cnt + 1'b1;
      base_q <= base_ev;
      tick_q <= base_ev & (&cnt);
      per_q  <= base_ev & per_hit;
    end
  end

  assign tick_1hz  = tick_q;
  assign per_pulse = per_q;
  assign sqw_out   = sqw_en & ((rate_sel == 4'd1) ? base_q : ((rate_sel != 4'd0) & cnt[tap]));
endmodule

module rate_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_en,
  input logic [2:0] div_sel,
  input logic [3:0] rate_sel,
  input logic       sqw_en,
  input logic       tick_1hz,
  input logic       per_pulse,
  input logic       sqw_out
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!tick_1hz && !per_pulse && !sqw_out));

  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel[2] && div_sel[1]) |=> (!tick_1hz && !per_pulse));

  assert_rate_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !per_pulse);

  assert_rate_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |-> !sqw_out);

  assert_sqw_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_en |-> !sqw_out);

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz |=> !tick_1hz);

  assert_no_ref_no_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> (!tick_1hz && !per_pulse));
endmodule

bind rate_divider rate_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .div_sel(div_sel),
  .rate_sel(rate_sel), .sqw_en(sqw_en), .tick_1hz(tick_1hz),
  .per_pulse(per_pulse), .sqw_out(sqw_out)
);

// File: tb/sim_rate_divider.sv
module sim_rate_divider;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {div_sel, rate_sel, pulse period in cycles, sqw high cycles per period}, ref_en held high
  localparam logic [38:0] VEC [NV] = '{
    {3'b010, 4'd1, 16'd1,   16'd1},
    {3'b010, 4'd2, 16'd2,   16'd1},
    {3'b010, 4'd5, 16'd16,  16'd8},
    {3'b010, 4'd9, 16'd256, 16'd128},
    {3'b001, 4'd1, 16'd32,  16'd1},
    {3'b001, 4'd4, 16'd256, 16'd128},
    {3'b000, 4'd2, 16'd256, 16'd128},
    {3'b000, 4'd3, 16'd512, 16'd256}
  };

  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b1, sqw_en = 1'b1;
  logic [2:0] div_sel = 3'b010;
  logic [3:0] rate_sel = 4'd0;
  logic tick_1hz, per_pulse, sqw_out;
  int checks = 0, errors = 0, cycles = 0;

  rate_divider u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap(output int g);
    int n = 0;
    while (!per_pulse && n < 5000) begin @(negedge clk); n++; end
    g = 0;
    do begin @(negedge clk); g++; end while (!per_pulse && g < 5000);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    int g, hi, n, pulses;
    logic lvl;
    rate_sel = 4'd2;
    repeat (3) @(negedge clk);
    check(!tick_1hz && !per_pulse && !sqw_out, "R1", {tick_1hz, per_pulse, sqw_out}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      div_sel = VEC[i][38:36]; rate_sel = VEC[i][35:32];
      gap(g);
      gap(g);
      check(g == int'(VEC[i][31:16]), $sformatf("R2/R6 vec%0d period", i), g, int'(VEC[i][31:16]));
      hi = 0;
      for (int c = 0; c < int'(VEC[i][31:16]); c++) begin
        if (sqw_out) hi++;
        @(negedge clk);
      end
      check(hi == int'(VEC[i][15:0]), $sformatf("R7 vec%0d sqw high", i), hi, int'(VEC[i][15:0]));
    end

    // R5: rate code 0
    @(negedge clk); div_sel = 3'b010; rate_sel = 4'd0;
    pulses = 0; hi = 0;
    repeat (1000) begin @(negedge clk); if (per_pulse) pulses++; if (sqw_out) hi++; end
    check(pulses == 0, "R5 pulses", pulses, 0);
    check(hi == 0, "R5 sqw", hi, 0);

    // R8: enable low, pulses continue
    rate_sel = 4'd3; sqw_en = 1'b0;
    pulses = 0; hi = 0;
    repeat (64) begin @(negedge clk); if (per_pulse) pulses++; if (sqw_out) hi++; end
    check(hi == 0, "R8 sqw", hi, 0);
    check(pulses == 16, "R8 pulses", pulses, 16);
    sqw_en = 1'b1;

    // R10: ref_en low freezes
    rate_sel = 4'd2;
    @(negedge clk); lvl = sqw_out; ref_en = 1'b0;
    pulses = 0; n = 0;
    repeat (50) begin @(negedge clk); if (per_pulse) pulses++; if (sqw_out != lvl) n++; end
    check(pulses == 0, "R10 pulses", pulses, 0);
    check(n == 0, "R10 sqw stable", n, 0);
    ref_en = 1'b1;

    // R4: freeze codes keep state
    for (int d = 3; d <= 5; d++) begin
      @(negedge clk); lvl = sqw_out; div_sel = 3'(d);
      pulses = 0; n = 0;
      repeat (40) begin @(negedge clk); if (per_pulse) pulses++; if (sqw_out != lvl) n++; end
      check(pulses == 0 && n == 0, $sformatf("R4 code %0d", d), pulses + n, 0);
      div_sel = 3'b010;
    end

    // R3: clear codes
    for (int d = 6; d <= 7; d++) begin
      @(negedge clk); div_sel = 3'(d); rate_sel = 4'd1;
      pulses = 0; hi = 0;
      repeat (500) begin @(negedge clk); if (per_pulse || tick_1hz) pulses++; if (sqw_out) hi++; end
      check(pulses == 0 && hi == 0, $sformatf("R3 code %0d", d), pulses + hi, 0);
    end

    // R9: first tick one second after release, then every second
    rate_sel = 4'd0;
    @(negedge clk); div_sel = 3'b010;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_1hz && n < 40000);
    check(n == 32768, "R9 first tick", n, 32768);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_1hz && n < 40000);
    check(n == 32768, "R9 tick spacing", n, 32768);

    // R1: reset mid-run
    rate_sel = 4'd2; rst_n = 1'b0;
    @(negedge clk);
    check(!tick_1hz && !per_pulse && !sqw_out, "R1 mid-run", {tick_1hz, per_pulse, sqw_out}, 0);
    finish_run();
  end
endmodule